// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Processor Core

This block is a small sequential processor for a 16-bit load/store machine with sixteen opcodes. It holds a program counter and sixteen 16-bit general registers, where register 0 always reads as zero. It executes one instruction at a time. The core fetches the word at the program counter from an external word-addressed memory and advances the counter by one. It then performs the decoded operation: register arithmetic, immediate loads, relative branches, memory loads and stores, a register-indirect jump that saves a return address, or a system call.

The memory port has a single address bus, with separate read and write strobes. Read data arrives one cycle after the read strobe. A system call raises a request that carries the value of register 1. The core stalls until the environment acknowledges the request, then continues with the next instruction. A divide by a zero divisor stops the core: it raises `halted`, makes no further memory accesses, and keeps its state until reset.

Top module: `cpu16_core`

## Requirements
- R1: After reset the PC is 0. Each instruction is fetched by a read at the PC address, and the data arrives one cycle later. The PC then becomes PC+1 before the instruction takes effect. An instruction takes 2 clock cycles, and a load takes 3. The fields are: opcode [15:12], ra [11:8], rb [7:4], rc [3:0], 8-bit immediate [7:0], 4-bit signed offset [3:0].
- R2: The opcodes 0 add, 1 sub, 2 multiply (low 16 bits), 4 shift left and 5 logical shift right by Reg[rc] & 15 with zero fill, and 6 NOR all write f(Reg[rb], Reg[rc]) to ra.
- R3: Opcode 3 writes the signed quotient Reg[rb]/Reg[rc], truncated toward zero and kept to 16 bits (0x8000 / 0xFFFF gives 0x8000). Opcode 7 writes 1 when Reg[rb] < Reg[rc] as signed values, and 0 otherwise.
- R4: Register 0 reads as zero in every use, and writes to it are discarded.
- R5: Opcode 8 writes the sign-extended 8-bit immediate to ra. Opcode 9 writes the immediate to bits [15:8] and zeros to bits [7:0].
- R6: Opcode 10 (taken when Reg[ra] is zero) and opcode 11 (taken when Reg[ra] is nonzero) set PC to PC+1+sext(imm8) when taken, and fall through otherwise.
- R7: Opcode 12 loads memory[Reg[rb] + sext(offset4)] into ra. Opcode 13 writes Reg[ra] to that address. The address wraps modulo 2^16.
- R8: Opcode 14 writes PC+1 to ra and jumps to the value Reg[rb] held before that write, which also holds when ra equals rb. Bits [3:0] are ignored.
- R9: Opcode 15 raises sys_req with sys_num equal to Reg[1]. The core holds sys_req and the PC, and makes no memory access, until sys_ack. It then continues at the next instruction.
- R10: A divide whose divisor register is zero writes nothing and raises halted. From then on the core makes no memory access and executes no further instruction until reset.
- R11: An asynchronous active-low reset clears the PC and all registers, and clears halted and sys_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_rd_en | output | 1 | Read strobe; data is returned on the following cycle |
| mem_rd_data | input | 16 | Read data, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Write strobe for a store |
| mem_wr_data | output | 16 | Store data |
| sys_req | output | 1 | System call pending |
| sys_num | output | 16 | Service number (register 1) while sys_req is high |
| sys_ack | input | 1 | Ends the system call stall |
| halted | output | 1 | Core stopped by a divide by zero |

## Verification
Random straight-line programs mix every register operation with immediate loads, loads and stores through a fixed base register. Writes to register 0 are included. Their final memory images are compared with an instruction-level model, which separates errors in operand selection, immediate extension and result width. Directed programs cover the remaining cases. Signed division overflow and shift amounts above 15 expose wrong arithmetic. Taken and untaken branches in both directions, and a jump whose link and target register are the same, expose wrong PC arithmetic. Two system calls with distinct numbers check the stall. A program whose registers are dumped right after reset, and a store placed after the halting divide, check reset clearing and that nothing runs after the halt. A cycle count on a known program checks the 2- and 3-cycle timing.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_SLL  = 4'h4,
    OP_SRL  = 4'h5,
    OP_NOR  = 4'h6,
    OP_SLT  = 4'h7,
    OP_LI   = 4'h8,
    OP_LUI  = 4'h9,
    OP_BEQZ = 4'hA,
    OP_BNEZ = 4'hB,
    OP_LW   = 4'hC,
    OP_SW   = 4'hD,
    OP_JALR = 4'hE,
    OP_SYS  = 4'hF
  } opc_t;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_EXEC,
    ST_LOAD,
    ST_SYS,
    ST_HALT
  } state_t;

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [RW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b,
  input  logic [RW-1:0] raddr_c,
  output logic [DW-1:0] rdata_c,
  output logic [DW-1:0] rdata_sys
);

  logic [DW-1:0] regs [NREG];

  // R4: entry 0 is a constant, so no write can reach it
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
        assign regs[i] = '0;
      end else begin : g_flop
        logic wr_hit;
        assign wr_hit = we && (waddr == RW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      regs[i] <= '0;
          else if (wr_hit) regs[i] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata_a   = regs[raddr_a];
  assign rdata_b   = regs[raddr_b];
  assign rdata_c   = regs[raddr_c];
  assign rdata_sys = regs[1];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int DW  = 16,
  localparam int SHW = $clog2(DW)
) (
  input  opc_t          op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res,
  output logic          div_zero
);

  logic signed [DW:0] num_x, den_x, quo_x;
  logic               lt_s;

  assign div_zero = (op == OP_DIV) && (rhs == '0);
  assign num_x    = {lhs[DW-1], lhs};
  // a zero divisor is replaced so the quotient stays defined; the result is discarded
  assign den_x    = (rhs == '0) ? (DW+1)'(1) : {rhs[DW-1], rhs};
  assign quo_x    = num_x / den_x;
  assign lt_s     = $signed(lhs) < $signed(rhs);

  always_comb begin
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      OP_DIV:  res = quo_x[DW-1:0];
      OP_SLL:  res = lhs << rhs[SHW-1:0];
      OP_SRL:  res = lhs >> rhs[SHW-1:0];
      OP_NOR:  res = ~(lhs | rhs);
      OP_SLT:  res = {{(DW-1){1'b0}}, lt_s};
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd_en,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [DW-1:0] mem_wr_data,
  output logic          sys_req,
  output logic [DW-1:0] sys_num,
  input  logic          sys_ack,
  output logic          halted
);

  localparam int RW = $clog2(NREG);

  state_t        state_q, state_d;
  logic [DW-1:0] pc_q, pc_d, ir_q;
  logic          ir_en;
  logic [DW-1:0] instr, pc_inc, imm8_x, off4_x, eff_addr;
  opc_t          opc;
  logic [RW-1:0] f_ra, f_rb, f_rc;
  logic [DW-1:0] rd_a, rd_b, rd_c, rd_sys, alu_res;
  logic          alu_dz;
  logic          rf_we;
  logic [DW-1:0] rf_wdata;

  // R1: read data of the fetch is decoded directly in the execute cycle
  assign instr    = (state_q == ST_EXEC) ? mem_rd_data : ir_q;
  assign opc      = opc_t'(instr[15:12]);
  assign f_ra     = instr[8 +: RW];
  assign f_rb     = instr[4 +: RW];
  assign f_rc     = instr[0 +: RW];
  assign imm8_x   = {{(DW-8){instr[7]}}, instr[7:0]};
  assign off4_x   = {{(DW-4){instr[3]}}, instr[3:0]};
  assign pc_inc   = pc_q + 1'b1;
  assign eff_addr = rd_b + off4_x;

  cpu16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(f_ra), .wdata(rf_wdata),
    .raddr_a(f_ra), .rdata_a(rd_a),
    .raddr_b(f_rb), .rdata_b(rd_b),
    .raddr_c(f_rc), .rdata_c(rd_c),
    .rdata_sys(rd_sys)
  );

  cpu16_alu #(.DW(DW)) u_alu (
    .op(opc), .lhs(rd_b), .rhs(rd_c), .res(alu_res), .div_zero(alu_dz)
  );

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    ir_en       = 1'b0;
    rf_we       = 1'b0;
    rf_wdata    = alu_res;
    mem_addr    = pc_q;
    mem_rd_en   = 1'b0;
    mem_wr_en   = 1'b0;
    mem_wr_data = rd_a;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd_en = 1'b1;
        state_d   = ST_EXEC;
      end
      ST_EXEC: begin
        ir_en   = 1'b1;
        pc_d    = pc_inc;
        state_d = ST_FETCH;
        unique case (opc)
          OP_LI:   begin rf_we = 1'b1; rf_wdata = imm8_x; end
          OP_LUI:  begin rf_we = 1'b1; rf_wdata = {instr[7:0], {(DW-8){1'b0}}}; end
          OP_BEQZ: if (rd_a == '0) pc_d = pc_inc + imm8_x;
          OP_BNEZ: if (rd_a != '0) pc_d = pc_inc + imm8_x;
          OP_LW: begin
            mem_rd_en = 1'b1;
            mem_addr  = eff_addr;
            state_d   = ST_LOAD;
          end
          OP_SW: begin
            mem_wr_en = 1'b1;
            mem_addr  = eff_addr;
          end
          OP_JALR: begin
            rf_we    = 1'b1;
            rf_wdata = pc_inc;
            pc_d     = rd_b;     // R8: old value of rb, write lands at the edge
          end
          OP_SYS:  state_d = ST_SYS;
          default: begin
            if (alu_dz) begin
              state_d = ST_HALT;
              pc_d    = pc_q;
            end else begin
              rf_we = 1'b1;
            end
          end
        endcase
      end
      ST_LOAD: begin
        rf_we    = 1'b1;
        rf_wdata = mem_rd_data;
        state_d  = ST_FETCH;
      end
      ST_SYS:  if (sys_ack) state_d = ST_FETCH;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= instr;
  end

  assign sys_req = (state_q == ST_SYS);
  assign sys_num = rd_sys;
  assign halted  = (state_q == ST_HALT);

  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd_en && !mem_wr_en);
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && !sys_ack |=> sys_req && $stable(pc_q) && $stable(sys_num));
  a_r9_req_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req |-> !mem_rd_en && !mem_wr_en);
  a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

endmodule

// File: tb/cpu16_core_bench.sv
`timescale 1ns/1ps
module cpu16_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr, mem_rd_data, mem_wr_data, sys_num;
  logic        mem_rd_en, mem_wr_en, sys_req, sys_ack, halted;

  always #5 clk = ~clk;

  cpu16_core u_cpu16_core (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
    .sys_req(sys_req), .sys_num(sys_num), .sys_ack(sys_ack), .halted(halted)
  );

  logic [15:0] mem     [0:1023];
  logic [15:0] ref_mem [0:1023];
  logic [15:0] prog    [0:1023];
  logic [15:0] rr      [0:15];
  logic [15:0] exp_sys [0:15];
  logic [15:0] got_sys [0:15];
  int exp_sys_n, got_sys_n, pw, cyc, total_cyc;
  int checks = 0, errors = 0;

  // memory model: one-cycle read latency, address wraps at 1024 words
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_addr[9:0]];
  end

  initial begin
    forever begin
      @(posedge clk);
      total_cyc++;
      if (total_cyc > 150000) begin
        errors++;
        $display("FAIL R1 watchdog expired: actual %0d cycles expected fewer", total_cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] e_r(int op, int a, int b, int c);
    return {op[3:0], a[3:0], b[3:0], c[3:0]};
  endfunction
  function automatic logic [15:0] e_i(int op, int a, int imm);
    return {op[3:0], a[3:0], imm[7:0]};
  endfunction

  task automatic put(input logic [15:0] w);
    prog[pw] = w;
    pw++;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 1024; i++) prog[i] = 16'h0000;
    pw = 0;
  endtask

  // store r0..r14 at 0x0200-8.., halt by divide by zero, then a store that must never run
  task automatic emit_dump();
    put(e_i(9, 15, 8'h02));
    for (int i = 0; i < 15; i++) put(e_r(13, i, 15, (i - 8) & 15));
    put(e_r(3, 1, 1, 0));
    put(e_r(13, 3, 0, 5));
  endtask

  // instruction-level model built from the requirements
  task automatic iss_run();
    logic [15:0] pc, ins, a, b, c, ad, t;
    int op, ra, rb, rc, q;
    bit stop;
    pc = 0; stop = 0; exp_sys_n = 0;
    for (int i = 0; i < 16; i++) rr[i] = 16'h0;
    for (int s = 0; s < 5000 && !stop; s++) begin
      ins = ref_mem[pc[9:0]];
      pc  = pc + 16'd1;
      op = int'(ins[15:12]); ra = int'(ins[11:8]); rb = int'(ins[7:4]); rc = int'(ins[3:0]);
      a = rr[ra]; b = rr[rb]; c = rr[rc];
      t = 16'h0;
      case (op)
        0: t = b + c;
        1: t = b - c;
        2: t = b * c;
        3: if (c == 0) stop = 1;
           else begin q = int'($signed(b)) / int'($signed(c)); t = q[15:0]; end
        4: t = b << c[3:0];
        5: t = b >> c[3:0];
        6: t = ~(b | c);
        7: t = ($signed(b) < $signed(c)) ? 16'd1 : 16'd0;
        8: t = {{8{ins[7]}}, ins[7:0]};
        9: t = {ins[7:0], 8'h00};
        10: if (a == 0) pc = pc + {{8{ins[7]}}, ins[7:0]};
        11: if (a != 0) pc = pc + {{8{ins[7]}}, ins[7:0]};
        12: begin ad = b + {{12{ins[3]}}, ins[3:0]}; t = ref_mem[ad[9:0]]; end
        13: begin ad = b + {{12{ins[3]}}, ins[3:0]}; ref_mem[ad[9:0]] = a; end
        14: begin t = pc; pc = b; end
        default: begin if (exp_sys_n < 16) exp_sys[exp_sys_n] = rr[1]; exp_sys_n++; end
      endcase
      if (!stop && (op <= 9 || op == 12 || op == 14) && ra != 0) rr[ra] = t;
    end
  endtask

  task automatic run_prog(input string name, input int limit);
    int wait_cnt, bad_q, mism, first;
    rst_n = 1'b0; sys_ack = 1'b0;
    for (int i = 0; i < 1024; i++) begin mem[i] = prog[i]; ref_mem[i] = prog[i]; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; got_sys_n = 0; wait_cnt = 0; bad_q = 0;
    do begin
      @(negedge clk);
      cyc++;
      sys_ack = 1'b0;
      if (sys_req) begin
        if (mem_rd_en || mem_wr_en) bad_q++;
        if (wait_cnt == 0) begin
          if (got_sys_n < 16) got_sys[got_sys_n] = sys_num;
          got_sys_n++;
        end
        wait_cnt++;
        if (wait_cnt == 3) begin sys_ack = 1'b1; wait_cnt = 0; end
      end
    end while (!halted && cyc < limit);
    iss_run();
    chk(halted === 1'b1, {"R10 halt reached in ", name}, 32'(halted), 32'd1);
    mism = 0; first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== ref_mem[i]) begin mism++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    chk(mism == 0, $sformatf("R2 R4 R5 R7 memory image of %s at word %0d", name, first),
        32'(mem[first]), 32'(ref_mem[first]));
    chk(got_sys_n == exp_sys_n, {"R9 system call count in ", name}, 32'(got_sys_n), 32'(exp_sys_n));
    for (int i = 0; i < exp_sys_n && i < got_sys_n && i < 16; i++)
      chk(got_sys[i] === exp_sys[i], {"R9 system call number in ", name}, 32'(got_sys[i]), 32'(exp_sys[i]));
    chk(bad_q == 0, {"R9 no memory access while stalled in ", name}, 32'(bad_q), 32'd0);
    bad_q = 0;
    repeat (6) begin
      @(negedge clk);
      if (!halted || mem_rd_en || mem_wr_en) bad_q++;
    end
    chk(bad_q == 0, {"R10 halted core stays quiet in ", name}, 32'(bad_q), 32'd0);
  endtask

  initial begin
    int k, ra, rb, rc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sys_ack = 1'b0; total_cyc = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (2) @(negedge clk);
    // R11: reset state at the ports
    chk(halted === 1'b0, "R11 halted low in reset", 32'(halted), 32'd0);
    chk(sys_req === 1'b0, "R11 sys_req low in reset", 32'(sys_req), 32'd0);
    chk(mem_wr_en === 1'b0, "R11 no write in reset", 32'(mem_wr_en), 32'd0);
    chk(mem_rd_en === 1'b1 && mem_addr === 16'h0, "R1 first fetch at address 0",
        {mem_rd_en, 15'h0, mem_addr}, {1'b1, 31'h0});

    // R1: cycle count, 4 x li (2 cycles) + lw (3) + halting divide (2)
    clear_prog();
    for (int i = 1; i < 5; i++) put(e_i(8, i, i));
    put(e_r(12, 5, 0, 0));
    put(e_r(3, 1, 1, 0));
    put(e_r(13, 2, 0, 5));
    run_prog("timing", 100);
    chk(cyc == 13, "R1 cycles to halt", 32'(cyc), 32'd13);

    // R3 R2 R4: arithmetic corners
    clear_prog();
    put(e_i(9, 1, 8'h80));      // r1 = 0x8000
    put(e_i(8, 2, 8'hFF));      // r2 = -1
    put(e_r(3, 3, 1, 2));       // 0x8000 / -1 -> 0x8000
    put(e_i(8, 4, 8'hF9));      // r4 = -7
    put(e_i(8, 5, 8'h02));
    put(e_r(3, 6, 4, 5));       // -3
    put(e_r(7, 7, 4, 5));       // 1
    put(e_r(7, 8, 5, 4));       // 0
    put(e_i(8, 10, 8'h13));     // shift amount 19 -> 3
    put(e_r(4, 9, 5, 10));      // 16
    put(e_r(5, 11, 4, 10));     // 0x1FFF
    put(e_r(2, 12, 4, 4));      // 49
    put(e_r(0, 0, 4, 4));       // write to r0 discarded
    put(e_r(0, 13, 0, 0));
    put(e_r(6, 14, 4, 0));      // 6
    emit_dump();
    run_prog("arith corners", 400);
    chk(mem[16'h0200 - 8 + 3] === 16'h8000, "R3 signed overflow quotient", 32'(mem[16'h0200-8+3]), 32'h8000);
    chk(mem[16'h0200 - 8 + 6] === 16'hFFFD, "R3 quotient truncates toward zero", 32'(mem[16'h0200-8+6]), 32'hFFFD);
    chk(mem[16'h0200 - 8 + 11] === 16'h1FFF, "R2 logical right shift by rc&15", 32'(mem[16'h0200-8+11]), 32'h1FFF);
    chk(mem[16'h0200 - 8 + 13] === 16'h0000, "R4 register 0 reads zero", 32'(mem[16'h0200-8+13]), 32'h0);

    // R6 R8 R9 R5: control flow and system calls
    clear_prog();
    put(e_i(8, 1, 0));          // 0
    put(e_i(10, 1, 1));         // 1: taken -> 3
    put(e_i(8, 2, 8'h55));      // 2: skipped
    put(e_i(11, 1, 1));         // 3: not taken
    put(e_i(8, 3, 7));          // 4
    put(e_i(8, 5, 3));          // 5
    put(e_i(8, 6, 8'hFF));      // 6
    put(e_r(0, 5, 5, 6));       // 7
    put(e_i(11, 5, 8'hFE));     // 8: back to 7
    put(e_i(8, 7, 12));         // 9
    put(e_r(14, 7, 7, 0));      // 10: r7 = 11, jump 12
    put(e_i(8, 8, 8'h11));      // 11: skipped
    put(e_i(8, 1, 8'h2A));      // 12
    put(16'hF123);              // 13: system call, data bits ignored
    put(e_i(9, 9, 8'hA5));      // 14
    put(e_i(8, 1, 8'hFD));      // 15
    put(16'hF000);              // 16
    put(e_i(10, 0, 2));         // 17: -> 20
    put(e_i(8, 10, 1));
    put(e_i(8, 10, 1));
    emit_dump();
    run_prog("control flow", 600);
    chk(got_sys[0] === 16'h002A, "R9 first service number", 32'(got_sys[0]), 32'h2A);
    chk(mem[16'h0200 - 8 + 7] === 16'd11, "R8 link with ra equal rb", 32'(mem[16'h0200-8+7]), 32'd11);
    chk(mem[16'h0200 - 8 + 2] === 16'h0000, "R6 taken branch skips", 32'(mem[16'h0200-8+2]), 32'h0);
    chk(mem[16'h0200 - 8 + 9] === 16'hA500, "R5 upper immediate zero fill", 32'(mem[16'h0200-8+9]), 32'hA500);

    // R11: registers cleared by reset (dump right away after a run that left them set)
    clear_prog();
    emit_dump();
    run_prog("reset clears registers", 200);
    chk(mem[16'h0200 - 8 + 14] === 16'h0000, "R11 register cleared by reset", 32'(mem[16'h0200-8+14]), 32'h0);

    // R2 R5 R7 R4: random straight-line programs
    for (int t = 0; t < 6; t++) begin
      clear_prog();
      put(e_i(9, 15, 8'h02));
      for (int i = 1; i < 5; i++) put(e_i(8, i, int'($urandom % 256)));
      for (int n = 0; n < 40; n++) begin
        k  = int'($urandom % 12);
        ra = int'($urandom % 15);
        rb = int'($urandom % 16);
        rc = int'($urandom % 16);
        case (k)
          8:  put(e_i(8, ra, int'($urandom % 256)));
          9:  put(e_i(9, ra, int'($urandom % 256)));
          10: put(e_r(12, ra, 15, rc));
          11: put(e_r(13, ra, 15, rc));
          default: put(e_r(k, ra, rb, rc));
        endcase
      end
      emit_dump();
      run_prog($sformatf("random %0d", t), 1000);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule